// File: doc/BRIEF.md
# Configuration Soft-Error CRC Checker

This block checks that the configuration memory of a device has not been changed by soft errors while the device is running. Once it is enabled and told to start, it reads the whole configuration image one bit at a time through a read port. It addresses the image by frame number and by bit position within the frame, and it folds each returned bit into a running CRC-32. When the last bit has arrived, it compares the result with the expected CRC that was captured at start. A mismatch raises an error flag. The flag stays high until the next accepted start or a reset. What to do about an error is left to the surrounding system: ignore it, log it, or reload the configuration.

The read port has two valid/ready channels. The request channel carries addresses. The checker holds `req_valid` together with a stable address until the memory accepts it with `req_ready`, so the memory can stall requests for as long as it likes. Requests may run ahead of the data. The memory must return exactly one data beat per accepted request, in the order the requests were accepted. The data channel has no back-pressure: `dat_ready` is always high. Beats that arrive while no scan is running are accepted and thrown away, so any response still in flight after an abort is drained. Control and status pins are plain levels or pulses.

The scan length is FRAMES × FRAME_BITS bits. With a memory that never stalls, the checker moves one bit per clock.

Top module: `cfgscan_checker`

## Requirements
- R1: After reset, `busy`, `done`, `error` and `req_valid` are 0 and `dat_ready` is 1.
- R2: A cycle in which `enable` and `start` are both high while `busy` is low is an accepted start. After it, `busy` is 1, `error` is 0, and `expected_crc` has been captured for the scan.
- R3: A scan issues exactly FRAMES×FRAME_BITS requests. Bits within a frame run from 0 up to FRAME_BITS-1, and frames run from 0 up to FRAMES-1. The linear index is frame×FRAME_BITS+bit. While `req_valid` is high and `req_ready` is low, the address is held stable.
- R4: The CRC is CRC-32 with polynomial 0x04C11DB7, preset to 0xFFFFFFFF, and no final XOR. Bits are taken in index order. Each bit is XORed with CRC bit 31, the CRC is shifted left by one, and the polynomial is XORed in when that XOR result was 1.
- R5: `done` is high for exactly one cycle, in the cycle after the handshake of the last data beat. `busy` is low in that same cycle.
- R6: `error` is set together with `done` if the final CRC differs from the captured expected value, and stays 0 if the two are equal.
- R7: `error` stays high until the next accepted start or a reset.
- R8: If `enable` goes low during a scan, the scan is aborted. `busy` and `req_valid` are low in the next cycle, `done` does not pulse, and `error` is not set.
- R9: A start raised while `busy` is high is ignored. The running scan keeps its captured expected value and ends after the normal number of beats, with a single `done` pulse.
- R10: A start with `enable` low is ignored. `busy` stays low and `error` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Checker enable; taking it low aborts a scan |
| start | input | 1 | Start request, used only while idle and enabled |
| expected_crc | input | 32 | Expected CRC, captured on an accepted start |
| busy | output | 1 | High while a scan is running |
| done | output | 1 | One-cycle pulse when a scan completes |
| error | output | 1 | Sticky CRC mismatch flag |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Memory accepts the read request |
| req_frame | output | $clog2(FRAMES) | Frame number of the request |
| req_bit | output | $clog2(FRAME_BITS) | Bit position within the frame |
| dat_valid | input | 1 | Returned data bit valid |
| dat_ready | output | 1 | Always 1; the checker never stalls data |
| dat_bit | input | 1 | Returned configuration bit |

## Verification
`busy` rises in the cycle after the edge that accepts a start. `done` and the updated `error` appear in the cycle after the edge that hands over the last data bit. An abort clears `busy` one cycle after `enable` falls. The bench drives and samples at the falling clock edge. It records the edge count at which its memory model sees the last data handshake, and requires `done` at exactly the following sample and gone at the sample after that. Scans are swept across zero, all-ones, walking-one and pseudo-random images, with and without request stalls, and the expected CRC is computed arithmetically in the bench.

// File: rtl/cfgscan_pkg.sv
package cfgscan_pkg;
  localparam int CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY   = 32'h04C1_1DB7;
  localparam logic [CRC_W-1:0] CRC_PRESET = 32'hFFFF_FFFF;

  typedef enum logic [0:0] {
    SCAN_IDLE = 1'b0,
    SCAN_RUN  = 1'b1
  } scan_state_e;

  // one message bit folded into the remainder, MSB first
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] cur,
                                                input logic b);
    logic fb;
    fb = cur[CRC_W-1] ^ b;
    return {cur[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction
endpackage

// File: rtl/cfgscan_addr_gen.sv
module cfgscan_addr_gen #(
  parameter int FRAMES     = 4,
  parameter int FRAME_BITS = 8,
  localparam int FW = (FRAMES > 1) ? $clog2(FRAMES) : 1,
  localparam int BW = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          active,
  input  logic          enable,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [FW-1:0] req_frame,
  output logic [BW-1:0] req_bit
);
  localparam logic [FW-1:0] LAST_FRAME = FW'(FRAMES - 1);
  localparam logic [BW-1:0] LAST_BIT   = BW'(FRAME_BITS - 1);

  logic [FW-1:0] frame_q;
  logic [BW-1:0] bit_q;
  logic          all_issued_q;
  logic          hs;

  assign req_valid = active && !all_issued_q;
  assign req_frame = frame_q;
  assign req_bit   = bit_q;
  assign hs        = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q      <= '0;
      bit_q        <= '0;
      all_issued_q <= 1'b0;
    end else if (clear) begin
      frame_q      <= '0;
      bit_q        <= '0;
      all_issued_q <= 1'b0;
    end else if (hs) begin
      if (bit_q == LAST_BIT) begin
        bit_q <= '0;
        if (frame_q == LAST_FRAME) begin
          all_issued_q <= 1'b1;
        end else begin
          frame_q <= frame_q + 1'b1;
        end
      end else begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end

  a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && enable) |=> (req_valid && $stable(req_frame) && $stable(req_bit)));

  a_r3_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_frame <= LAST_FRAME && req_bit <= LAST_BIT));

  a_r8_no_req_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !req_valid);
endmodule

// File: rtl/cfgscan_crc_engine.sv
module cfgscan_crc_engine
  import cfgscan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             beat,
  input  logic             bit_in,
  output logic [CRC_W-1:0] crc_next
);
  logic [CRC_W-1:0] crc_q;

  assign crc_next = crc_step(crc_q, bit_in);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q <= CRC_PRESET;
    end else if (clear) begin
      crc_q <= CRC_PRESET;
    end else if (beat) begin
      crc_q <= crc_next;
    end
  end

  a_r4_preset_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (crc_q == CRC_PRESET));

  a_r4_hold_without_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !beat) |=> $stable(crc_q));
endmodule

// File: rtl/cfgscan_ctrl.sv
module cfgscan_ctrl
  import cfgscan_pkg::*;
#(
  parameter int TOTAL = 32,
  localparam int CW = $clog2(TOTAL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             start,
  input  logic [CRC_W-1:0] expected_crc,
  input  logic             dat_valid,
  input  logic [CRC_W-1:0] crc_next,
  output logic             beat,
  output logic             start_acc,
  output logic             busy,
  output logic             done,
  output logic             error
);
  localparam logic [CW-1:0] LAST_IDX = CW'(TOTAL - 1);

  scan_state_e      state_q;
  logic [CW-1:0]    rcv_q;
  logic [CRC_W-1:0] exp_q;
  logic             last_beat;

  assign busy      = (state_q == SCAN_RUN);
  assign start_acc = (state_q == SCAN_IDLE) && enable && start;
  assign beat      = busy && enable && dat_valid;
  assign last_beat = beat && (rcv_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SCAN_IDLE;
      rcv_q   <= '0;
      exp_q   <= '0;
      done    <= 1'b0;
      error   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        SCAN_IDLE: begin
          if (start_acc) begin
            state_q <= SCAN_RUN;
            rcv_q   <= '0;
            exp_q   <= expected_crc;
            error   <= 1'b0;
          end
        end
        SCAN_RUN: begin
          if (!enable) begin
            state_q <= SCAN_IDLE;
          end else if (beat) begin
            rcv_q <= rcv_q + 1'b1;
            if (last_beat) begin
              state_q <= SCAN_IDLE;
              done    <= 1'b1;
              error   <= (crc_next != exp_q);
            end
          end
        end
        default: state_q <= SCAN_IDLE;
      endcase
    end
  end

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r5_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !enable) |=> (!busy && !done && !error));

  a_r9_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(enable && start));

  a_r9_hold_expect: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(exp_q));

  a_r7_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(error) |-> (done || busy));

  a_r10_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !enable) |=> !busy);
endmodule

// File: rtl/cfgscan_checker.sv
module cfgscan_checker
  import cfgscan_pkg::*;
#(
  parameter int FRAMES     = 4,
  parameter int FRAME_BITS = 8,
  localparam int FW    = (FRAMES > 1) ? $clog2(FRAMES) : 1,
  localparam int BW    = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1,
  localparam int TOTAL = FRAMES * FRAME_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          start,
  input  logic [31:0]   expected_crc,
  output logic          busy,
  output logic          done,
  output logic          error,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [FW-1:0] req_frame,
  output logic [BW-1:0] req_bit,
  input  logic          dat_valid,
  output logic          dat_ready,
  input  logic          dat_bit
);
  logic             beat;
  logic             start_acc;
  logic [CRC_W-1:0] crc_next;

  assign dat_ready = 1'b1;

  cfgscan_ctrl #(.TOTAL(TOTAL)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .start        (start),
    .expected_crc (expected_crc),
    .dat_valid    (dat_valid),
    .crc_next     (crc_next),
    .beat         (beat),
    .start_acc    (start_acc),
    .busy         (busy),
    .done         (done),
    .error        (error)
  );

  cfgscan_addr_gen #(.FRAMES(FRAMES), .FRAME_BITS(FRAME_BITS)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start_acc),
    .active    (busy),
    .enable    (enable),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_frame (req_frame),
    .req_bit   (req_bit)
  );

  cfgscan_crc_engine u_crc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start_acc),
    .beat     (beat),
    .bit_in   (dat_bit),
    .crc_next (crc_next)
  );

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!busy && !done && !error && !req_valid));
endmodule

// File: tb/cfgscan_checker_test.sv
module cfgscan_checker_test;
  localparam int FRAMES = 4;
  localparam int FRAME_BITS = 8;
  localparam int TOTAL = FRAMES * FRAME_BITS;
  localparam int FW = $clog2(FRAMES);
  localparam int BW = $clog2(FRAME_BITS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic start = 1'b0;
  logic [31:0] expected_crc = '0;
  logic busy, done, error, req_valid, req_ready, dat_valid, dat_ready, dat_bit;
  logic [FW-1:0] req_frame;
  logic [BW-1:0] req_bit;

  always #4 clk = ~clk;

  cfgscan_checker #(.FRAMES(FRAMES), .FRAME_BITS(FRAME_BITS)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start(start),
    .expected_crc(expected_crc), .busy(busy), .done(done), .error(error),
    .req_valid(req_valid), .req_ready(req_ready), .req_frame(req_frame),
    .req_bit(req_bit), .dat_valid(dat_valid), .dat_ready(dat_ready),
    .dat_bit(dat_bit)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int last_hs_cyc = -1;
  int iss_cnt = 0;
  int rx_cnt = 0;
  logic stall = 1'b0;
  logic clr = 1'b0;
  logic slot_v = 1'b0;
  logic slot_d = 1'b0;
  logic [TOTAL-1:0] mem_bits = '0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  assign req_ready = stall ? cyc[0] : 1'b1;
  assign dat_valid = slot_v;
  assign dat_bit   = slot_d;

  // memory model: one slot, in-order responses
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (clr) begin
      slot_v <= 1'b0;
      iss_cnt <= 0;
      rx_cnt <= 0;
    end else begin
      if (slot_v && dat_ready) begin
        rx_cnt <= rx_cnt + 1;
        if (busy && enable && rx_cnt == TOTAL - 1) last_hs_cyc <= cyc + 1;
      end
      if (req_valid && req_ready) begin
        check(int'(req_frame) * FRAME_BITS + int'(req_bit) == iss_cnt, "R3 order",
              int'(req_frame) * FRAME_BITS + int'(req_bit), iss_cnt);
        iss_cnt <= iss_cnt + 1;
        slot_v <= 1'b1;
        slot_d <= mem_bits[int'(req_frame) * FRAME_BITS + int'(req_bit)];
      end else if (slot_v && dat_ready) begin
        slot_v <= 1'b0;
      end
    end
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected <150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  function automatic logic [31:0] ref_crc(input logic [TOTAL-1:0] img);
    logic [31:0] r = 32'hFFFF_FFFF;
    for (int i = 0; i < TOTAL; i++) begin
      if (r[31] != img[i]) r = (r << 1) ^ 32'h04C1_1DB7;
      else r = r << 1;
    end
    return r;
  endfunction

  // full scan; mid_start pulses a second start with a wrong value mid-scan
  task automatic run_scan(input logic [31:0] expv, input bit exp_err, input bit mid_start);
    bit seen;
    @(negedge clk);
    expected_crc = expv; start = 1'b1; enable = 1'b1; clr = 1'b1;
    @(negedge clk);
    start = 1'b0; clr = 1'b0;
    check(busy == 1'b1, "R2 busy after start", busy, 1);
    check(error == 1'b0, "R2 error cleared at start", error, 0);
    seen = 1'b0;
    for (int k = 0; k < 400; k++) begin
      if (mid_start && k == 6) begin
        start = 1'b1; expected_crc = ~expv;
      end else begin
        start = 1'b0;
      end
      if (done) begin seen = 1'b1; break; end
      @(negedge clk);
    end
    start = 1'b0;
    check(seen, "R5 done pulse", seen, 1);
    check(cyc == last_hs_cyc, "R5 done timing", cyc, last_hs_cyc);
    check(busy == 1'b0, "R5 busy low with done", busy, 0);
    check(iss_cnt == TOTAL, "R3 request count", iss_cnt, TOTAL);
    check(error == exp_err, mid_start ? "R9 error after mid start" : "R6 error", error, exp_err);
    @(negedge clk);
    check(done == 1'b0, "R5 done one cycle", done, 0);
    check(error == exp_err, "R7 error held", error, exp_err);
    check(busy == 1'b0, "R9 no restart", busy, 0);
  endtask

  initial begin
    logic [31:0] lf;
    logic [31:0] good;
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && error == 0 && req_valid == 0, "R1 reset outputs",
          {busy, done, error, req_valid}, 0);
    check(dat_ready == 1'b1, "R1 dat_ready", dat_ready, 1);
    rst_n = 1'b1;
    enable = 1'b1;
    @(negedge clk);

    lf = 32'h1234_5679;
    for (int p = 0; p < 44; p++) begin
      if (p == 0) mem_bits = '0;
      else if (p == 1) mem_bits = '1;
      else if (p < 2 + TOTAL) mem_bits = TOTAL'(1) << (p - 2);
      else begin
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]} ^ 32'(p);
        mem_bits = TOTAL'(lf);
      end
      stall = p[0];
      good = ref_crc(mem_bits);
      run_scan(good, 1'b0, 1'b0);                 // R4 matching CRC
      if (p % 4 == 0) run_scan(good ^ (32'h1 << (p % 32)), 1'b1, 1'b0); // R6 mismatch
    end

    // R7: error stays, R10: start with enable low ignored
    mem_bits = 32'hA5C3_0F96;
    stall = 1'b0;
    run_scan(ref_crc(mem_bits) ^ 32'h8000_0000, 1'b1, 1'b0);
    repeat (20) @(negedge clk);
    check(error == 1'b1, "R7 sticky idle", error, 1);
    enable = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b0, "R10 busy stays low", busy, 0);
    check(req_valid == 1'b0, "R10 no requests", req_valid, 0);
    check(error == 1'b1, "R10 error kept", error, 1);
    enable = 1'b1;
    @(negedge clk);

    // R9: start while busy ignored, captured value kept
    run_scan(ref_crc(mem_bits), 1'b0, 1'b1);

    // R8: abort mid-scan
    @(negedge clk);
    expected_crc = 32'h0; start = 1'b1; clr = 1'b1;
    @(negedge clk);
    start = 1'b0; clr = 1'b0;
    repeat (9) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(busy == 1'b0, "R8 busy low after abort", busy, 0);
    check(req_valid == 1'b0, "R8 requests stop", req_valid, 0);
    begin
      bit any_done = 1'b0;
      for (int k = 0; k < 40; k++) begin
        if (done) any_done = 1'b1;
        @(negedge clk);
      end
      check(!any_done, "R8 no done after abort", any_done, 0);
      check(error == 1'b0, "R8 error not set", error, 0);
    end
    enable = 1'b1;
    repeat (3) @(negedge clk);
    run_scan(ref_crc(mem_bits), 1'b0, 1'b0);      // R8 recovers cleanly

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule